// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the interrupt side of a small byte-oriented controller core. It holds a request flag for each of eight sources and a mask bit for each. When the core signals that it may take an interrupt and the global enable is on, the block picks one unmasked pending source. It saves the status byte and the program counter on a stack that grows downward, then fetches a 16-bit handler address from a vector table. It loads that address into the program counter and turns interrupts off. On a return command it runs the reverse sequence: it pops the program counter and then the status byte.

The block owns the program counter, the stack pointer and the status byte while a sequence runs. The core loads them through plain write ports when the block is idle. All memory traffic uses one byte-wide valid/ready port. The block raises `mem_valid` with a stable address, direction and write data. It keeps them unchanged until the memory raises `mem_ready`, and each valid-and-ready cycle moves exactly one byte. Memory may hold `mem_ready` low for as long as it likes. Request strobes still land in the flag register during a stall.

Top module: `vint_ctrl`

## Requirements
- R1: A source is pending-and-enabled when its flag bit is 1 and its mask bit is 0. A masked source is never serviced. The mask register loads from `mask_wr_data` in any cycle where `mask_wr_en` is high.
- R2: An entry starts only in an idle cycle where `ack_en` is high, status bit 7 (the global enable) is 1, `ret_cmd` is low, and at least one source is pending-and-enabled. Otherwise the bus stays quiet.
- R3: The lowest-numbered pending-and-enabled source wins. Its vector address is 0x0006 + 2 × index.
- R4: Accepting a source clears only that source's flag. A strobe on the same bit in the accepting cycle keeps the flag set. Strobes at any time, including while busy, set flags. A flag write loads the register, the acceptance clear is applied after it, and strobes are OR-ed in last.
- R5: Entry writes the status byte at SP−1, then PC[15:8] at SP−2, then PC[7:0] at SP−3. SP drops by one with each completed write.
- R6: After the pushes, entry reads the low handler byte at the vector address and the high byte at vector address + 1. Completing the second read loads the PC and clears status bit 7. `busy` drops in the following cycle.
- R7: When idle, `ret_cmd` starts a return, and it takes priority over an entry in the same cycle. The return reads PC[7:0] at SP, PC[15:8] at SP+1 and the status byte at SP+2. SP rises by one after each read, and the whole status byte, global enable included, is restored.
- R8: `mem_valid` equals `busy`. While `mem_valid` is high and `mem_ready` is low, address, direction and write data stay stable. Read data is taken in the cycle where valid and ready are both high.
- R9: Writes to PC, SP and the status byte take effect only in an idle cycle that starts no sequence. At any other time they are ignored.
- R10: After reset the block is idle and flags, mask, PC, SP and status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_strobe | input | 8 | One-cycle request pulses, one per source |
| flag_wr_en | input | 1 | Load the flag register |
| flag_wr_data | input | 8 | Flag register load value |
| mask_wr_en | input | 1 | Load the mask register |
| mask_wr_data | input | 8 | Mask register load value (1 = masked) |
| psw_wr_en | input | 1 | Load the status byte |
| psw_wr_data | input | 8 | Status byte load value; bit 7 is the global enable |
| pc_wr_en | input | 1 | Load the program counter |
| pc_wr_data | input | 16 | Program counter load value |
| sp_wr_en | input | 1 | Load the stack pointer |
| sp_wr_data | input | 16 | Stack pointer load value |
| ack_en | input | 1 | Core allows an interrupt to be accepted this cycle |
| ret_cmd | input | 1 | Start a return-from-interrupt sequence |
| mem_valid | output | 1 | Byte transfer requested |
| mem_ready | input | 1 | Memory accepts or returns the byte |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when mem_valid and mem_ready |
| busy | output | 1 | Entry or return sequence in progress |
| flags | output | 8 | Request flag register |
| mask | output | 8 | Mask register |
| psw | output | 8 | Status byte |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The hardest case to reach is a new strobe that lands on a source in the exact cycle that source is accepted. The clear and the set then meet on one flag bit. The stimulus first leaves that one source pending with `ack_en` low. It then raises `ack_en` together with a strobe on the same bit, and afterwards checks that the flag is still set once the handler address is loaded. A long random phase with a stalling memory also mixes return commands with register writes issued while busy, to exercise back-pressure and the ignored-write rule.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PSW,
    ST_PUSH_PCH,
    ST_PUSH_PCL,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_POP_PCL,
    ST_POP_PCH,
    ST_POP_PSW
  } seq_state_t;
endpackage

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  // winner is pending and nothing below it is pending
  always_comb begin
    if (any) begin
      AST_PRIO_LOWEST: assert (pend[idx] && ((pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0)) else $error("priority pick wrong"); // R3
    end
  end
endmodule

// File: rtl/vint_flags.sv
module vint_flags #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] strobe,
  input  logic            flag_we,
  input  logic [NSRC-1:0] flag_wd,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wd,
  input  logic            clr_en,
  input  logic [IW-1:0]   clr_idx,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] flag_d;
  logic [NSRC-1:0] clr_vec;

  assign clr_vec = clr_en ? (NSRC'(1) << clr_idx) : '0;
  assign pend    = flag_q & ~mask_q;

  always_comb begin
    flag_d = flag_we ? flag_wd : flag_q;
    flag_d = flag_d & ~clr_vec;
    flag_d = flag_d | strobe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |=> ((flag_q & $past(strobe)) == $past(strobe))) else $error("strobe lost"); // R4
  AST_CLEAR_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !strobe[clr_idx]) |=> !flag_q[$past(clr_idx)]) else $error("serviced flag not cleared"); // R4
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int NSRC = 8,
  parameter logic [15:0] VEC_BASE = 16'h0006,
  parameter int VEC_STEP = 2,
  parameter int IE_BIT = 7,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_strobe,
  input  logic              flag_wr_en,
  input  logic [NSRC-1:0]   flag_wr_data,
  input  logic              mask_wr_en,
  input  logic [NSRC-1:0]   mask_wr_data,
  input  logic              psw_wr_en,
  input  logic [BYTE_W-1:0] psw_wr_data,
  input  logic              pc_wr_en,
  input  logic [ADDR_W-1:0] pc_wr_data,
  input  logic              sp_wr_en,
  input  logic [ADDR_W-1:0] sp_wr_data,
  input  logic              ack_en,
  input  logic              ret_cmd,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   mask,
  output logic [BYTE_W-1:0] psw,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);
  seq_state_t        state;
  logic [ADDR_W-1:0] vec_addr;
  logic [BYTE_W-1:0] vec_lo;
  logic [NSRC-1:0]   pend;
  logic              pick_any;
  logic [IW-1:0]     pick_idx;
  logic              idle, start_ret, start_int, xfer;

  assign idle      = (state == ST_IDLE);
  assign start_ret = idle && ret_cmd;
  assign start_int = idle && !ret_cmd && ack_en && psw[IE_BIT] && pick_any;
  assign xfer      = mem_valid && mem_ready;
  assign busy      = !idle;

  vint_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (req_strobe),
    .flag_we (flag_wr_en),
    .flag_wd (flag_wr_data),
    .mask_we (mask_wr_en),
    .mask_wd (mask_wr_data),
    .clr_en  (start_int),
    .clr_idx (pick_idx),
    .flag_q  (flags),
    .mask_q  (mask),
    .pend    (pend)
  );

  vint_prio #(.NSRC(NSRC)) u_prio (
    .pend (pend),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  // bus request decode per state
  always_comb begin
    mem_valid = !idle;
    mem_write = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_PSW: begin mem_write = 1'b1; mem_addr = sp - 16'd1; mem_wdata = psw;      end
      ST_PUSH_PCH: begin mem_write = 1'b1; mem_addr = sp - 16'd1; mem_wdata = pc[15:8]; end
      ST_PUSH_PCL: begin mem_write = 1'b1; mem_addr = sp - 16'd1; mem_wdata = pc[7:0];  end
      ST_VEC_LO:   mem_addr = vec_addr;
      ST_VEC_HI:   mem_addr = vec_addr + 16'd1;
      default:     mem_addr = sp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pc       <= '0;
      sp       <= '0;
      psw      <= '0;
      vec_addr <= '0;
      vec_lo   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_ret) begin
            state <= ST_POP_PCL;
          end else if (start_int) begin
            state    <= ST_PUSH_PSW;
            vec_addr <= VEC_BASE + (16'(pick_idx) * 16'(VEC_STEP));
          end else begin
            if (pc_wr_en)  pc  <= pc_wr_data;
            if (sp_wr_en)  sp  <= sp_wr_data;
            if (psw_wr_en) psw <= psw_wr_data;
          end
        end
        ST_PUSH_PSW: if (xfer) begin sp <= sp - 16'd1; state <= ST_PUSH_PCH; end
        ST_PUSH_PCH: if (xfer) begin sp <= sp - 16'd1; state <= ST_PUSH_PCL; end
        ST_PUSH_PCL: if (xfer) begin sp <= sp - 16'd1; state <= ST_VEC_LO;   end
        ST_VEC_LO:   if (xfer) begin vec_lo <= mem_rdata; state <= ST_VEC_HI; end
        ST_VEC_HI: if (xfer) begin
          pc          <= {mem_rdata, vec_lo};
          psw[IE_BIT] <= 1'b0;
          state       <= ST_IDLE;
        end
        ST_POP_PCL: if (xfer) begin pc[7:0]  <= mem_rdata; sp <= sp + 16'd1; state <= ST_POP_PCH; end
        ST_POP_PCH: if (xfer) begin pc[15:8] <= mem_rdata; sp <= sp + 16'd1; state <= ST_POP_PSW; end
        ST_POP_PSW: if (xfer) begin psw      <= mem_rdata; sp <= sp + 16'd1; state <= ST_IDLE;    end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))) else $error("request dropped or changed"); // R8
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mem_write) |=> (sp == $past(sp) - 16'd1)) else $error("push did not step SP down"); // R5
  AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (state == ST_POP_PCL || state == ST_POP_PCH || state == ST_POP_PSW)) |=> (sp == $past(sp) + 16'd1)) else $error("pop did not step SP up"); // R7
  AST_IE_OFF_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && state == ST_VEC_HI) |=> (!psw[IE_BIT] && !busy)) else $error("enable not cleared"); // R6
  AST_ENTRY_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !ret_cmd && !psw[IE_BIT]) |=> !busy) else $error("entry without enable"); // R2
endmodule

// File: tb/vint_ctrl_tb.sv
`timescale 1ns/1ps
module vint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_strobe = '0;
  logic        flag_wr_en = 1'b0;
  logic [7:0]  flag_wr_data = '0;
  logic        mask_wr_en = 1'b0;
  logic [7:0]  mask_wr_data = '0;
  logic        psw_wr_en = 1'b0;
  logic [7:0]  psw_wr_data = '0;
  logic        pc_wr_en = 1'b0;
  logic [15:0] pc_wr_data = '0;
  logic        sp_wr_en = 1'b0;
  logic [15:0] sp_wr_data = '0;
  logic        ack_en = 1'b0;
  logic        ret_cmd = 1'b0;
  logic        mem_valid, mem_write, busy;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, mem_rdata, flags, mask, psw;

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];

  int n_tests = 0;
  int n_fail  = 0;
  bit rdy_rand = 1'b0;

  always #2.5 clk = ~clk;

  vint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .ack_en(ack_en), .ret_cmd(ret_cmd),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .flags(flags), .mask(mask), .psw(psw), .pc(pc), .sp(sp)
  );

  // behavioural reference: step 0 idle, 1..3 pushes, 4..5 vector reads, 6..8 pops
  int          m_step;
  logic [7:0]  m_flags, m_mask, m_psw, m_lo;
  logic [15:0] m_pc, m_sp, m_vec;

  function automatic logic [15:0] m_addr();
    if (m_step >= 1 && m_step <= 3) return m_sp - 16'd1;
    if (m_step == 4) return m_vec;
    if (m_step == 5) return m_vec + 16'd1;
    return m_sp;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_flags = 0; m_mask = 0; m_psw = 0; m_pc = 0; m_sp = 0; m_vec = 0; m_lo = 0;
    end else begin
      logic [7:0] nf, pend, rd;
      int idx;
      if (mem_valid && mem_ready && mem_write) mem[mem_addr[7:0]] = mem_wdata;
      nf = flag_wr_en ? flag_wr_data : m_flags;
      pend = m_flags & ~m_mask;
      rd = mem[m_addr()];
      if (m_step == 0) begin
        if (ret_cmd) m_step = 6;
        else if (ack_en && m_psw[7] && pend != 0) begin
          idx = 0;
          for (int i = 7; i >= 0; i--) if (pend[i]) idx = i;
          nf[idx] = 1'b0;
          m_vec = 16'h0006 + 16'(2 * idx);
          m_step = 1;
        end else begin
          if (pc_wr_en)  m_pc  = pc_wr_data;
          if (sp_wr_en)  m_sp  = sp_wr_data;
          if (psw_wr_en) m_psw = psw_wr_data;
        end
      end else if (mem_ready) begin
        case (m_step)
          1, 2, 3: begin m_sp = m_sp - 1; m_step = m_step + 1; end
          4: begin m_lo = rd; m_step = 5; end
          5: begin m_pc = {rd, m_lo}; m_psw[7] = 1'b0; m_step = 0; end
          6: begin m_pc[7:0] = rd;  m_sp = m_sp + 1; m_step = 7; end
          7: begin m_pc[15:8] = rd; m_sp = m_sp + 1; m_step = 8; end
          default: begin m_psw = rd; m_sp = m_sp + 1; m_step = 0; end
        endcase
      end
      m_flags = nf | req_strobe;
      if (mask_wr_en) m_mask = mask_wr_data;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic [7:0] ew;
    ew = (m_step == 1) ? m_psw : (m_step == 2) ? m_pc[15:8] : m_pc[7:0];
    chk("R4 flags", 32'(flags), 32'(m_flags));
    chk("R1 mask", 32'(mask), 32'(m_mask));
    chk("R6 R7 pc", 32'(pc), 32'(m_pc));
    chk("R5 R7 sp", 32'(sp), 32'(m_sp));
    chk("R7 R9 psw", 32'(psw), 32'(m_psw));
    chk("R8 busy", 32'(busy), 32'(m_step != 0));
    chk("R8 valid", 32'(mem_valid), 32'(m_step != 0));
    if (m_step != 0) begin
      chk("R3 R5 addr", 32'(mem_addr), 32'(m_addr()));
      chk("R5 dir", 32'(mem_write), 32'(m_step >= 1 && m_step <= 3));
      if (m_step >= 1 && m_step <= 3) chk("R5 wdata", 32'(mem_wdata), 32'(ew));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    mem_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
  endtask

  task automatic clear_inputs();
    req_strobe = 0; flag_wr_en = 0; mask_wr_en = 0; psw_wr_en = 0;
    pc_wr_en = 0; sp_wr_en = 0; ack_en = 0; ret_cmd = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 200) begin tick(); guard++; end
  endtask

  task automatic finish_sim();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 8; i++) begin
      mem[6 + 2 * i] = 8'h10 + 8'(i);
      mem[7 + 2 * i] = 8'hA0 + 8'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 idle", 32'(busy), 0);
    chk("R10 regs", {flags, mask, psw, 8'h00}, 0);
    chk("R10 pc sp", {pc, sp}, 0);

    psw_wr_en = 1; psw_wr_data = 8'h85; pc_wr_en = 1; pc_wr_data = 16'h1234;
    sp_wr_en = 1; sp_wr_data = 16'h0080; mask_wr_en = 1; mask_wr_data = 8'h04;
    req_strobe = 8'h24;
    tick(); clear_inputs();
    chk("R4 strobes set", 32'(flags), 32'h24);

    // entry: bit 2 masked, bit 5 serviced (R1, R3)
    ack_en = 1; tick(); clear_inputs();
    chk("R2 entry started", 32'(busy), 1);
    sp_wr_en = 1; sp_wr_data = 16'h0040; pc_wr_en = 1; pc_wr_data = 16'hFFFF;
    tick(); clear_inputs();
    wait_idle();
    chk("R3 R6 handler pc", 32'(pc), 32'hA515);
    chk("R6 ie cleared", 32'(psw), 32'h05);
    chk("R1 R4 masked flag kept", 32'(flags), 32'h04);
    chk("R5 R9 sp after pushes", 32'(sp), 32'h007D);
    chk("R5 stacked psw", 32'(mem[8'h7F]), 32'h85);
    chk("R5 stacked pch", 32'(mem[8'h7E]), 32'h12);
    chk("R5 stacked pcl", 32'(mem[8'h7D]), 32'h34);

    // return restores everything (R7), also beating a pending entry
    ret_cmd = 1; ack_en = 1; tick(); clear_inputs();
    wait_idle();
    chk("R7 pc restored", 32'(pc), 32'h1234);
    chk("R7 psw restored", 32'(psw), 32'h85);
    chk("R7 sp restored", 32'(sp), 32'h0080);

    // R2: enable off blocks a pending unmasked source
    psw_wr_en = 1; psw_wr_data = 8'h05; mask_wr_en = 1; mask_wr_data = 8'h00;
    tick(); clear_inputs();
    ack_en = 1; tick(); tick(); clear_inputs();
    chk("R2 no entry with ie off", 32'(busy), 0);

    // R1: all masked blocks entry
    psw_wr_en = 1; psw_wr_data = 8'h80; mask_wr_en = 1; mask_wr_data = 8'hFF;
    tick(); clear_inputs();
    ack_en = 1; tick(); tick(); clear_inputs();
    chk("R1 no entry when masked", 32'(busy), 0);

    // R4 corner: strobe on the accepted bit in the accepting cycle
    flag_wr_en = 1; flag_wr_data = 8'h08; mask_wr_en = 1; mask_wr_data = 8'h00;
    psw_wr_en = 1; psw_wr_data = 8'h80; sp_wr_en = 1; sp_wr_data = 16'h00C0;
    tick(); clear_inputs();
    ack_en = 1; req_strobe = 8'h08; tick(); clear_inputs();
    wait_idle();
    chk("R4 same-cycle strobe keeps flag", 32'(flags), 32'h08);
    chk("R3 handler for source 3", 32'(pc), 32'hA313);

    // random phase with stalling memory
    rdy_rand = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      req_strobe   = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      flag_wr_en   = (($urandom % 40) == 0); flag_wr_data = 8'($urandom);
      mask_wr_en   = (($urandom % 30) == 0); mask_wr_data = 8'($urandom);
      psw_wr_en    = (($urandom % 10) == 0); psw_wr_data = 8'($urandom);
      pc_wr_en     = (($urandom % 10) == 0); pc_wr_data = 16'($urandom);
      sp_wr_en     = (($urandom % 25) == 0); sp_wr_data = 16'h0080 + 16'($urandom % 96);
      ack_en       = (($urandom % 2) == 0);
      ret_cmd      = (($urandom % 20) == 0);
      tick();
    end
    clear_inputs();
    rdy_rand = 1'b0;
    tick();
    wait_idle();
    chk("R8 ends idle", 32'(busy), 0);
    finish_sim();
  end
endmodule